// File: doc/BRIEF.md
# Clock-Generator Configuration Register Bank with Staged Commit

This block is the byte-wide register file behind the control interface of a clock-generation device. A simple synchronous port carries a write strobe, a read strobe, an 8-bit address and 8-bit data. The port reaches three configuration registers and one global register. The configuration registers hold the lock-indicator settings, the auxiliary-output routing, the first and third interface enable bits, and a 4-bit tuning field. The global register holds the freeze control and the second interface enable bit.

Each configuration register has a staged copy and an active copy. Software writes always land in the staged copy. While freeze is clear, the same write also lands in the active copy. While freeze is set, the active copies hold their values. Clearing freeze copies all staged values into the active copies on one clock edge, so the outputs move together. The active routing field is decoded into a one-hot select and a lock-indicator flag. A control-port enable flag is raised only when all three enable bits are set.

Top module: `cfgbank_top`

## Requirements
- R1: While `rst_n` is low, every staged copy, every active copy, the global register and `rd_data` are cleared to 0, so all outputs read 0.
- R2: With freeze clear, a write to 02h, 03h or 04h changes the derived outputs on the clock edge that accepts the write.
- R3: With freeze set, writes to 02h–04h are stored in the staged copies, and `aux_sel`, `lock_mode`, `lock_pol`, `lock_od`, `tune_field` and `ctrl_port_en` do not change.
- R4: A write to 05h that clears bit 3 while freeze is set copies all three staged values into the active copies on that same edge.
- R5: A read strobe at address A loads `rd_data` on the next edge with the value A held before that edge. For 02h–04h this is the staged value. `rd_data` holds between reads.
- R6: Register 05h uses bit 3 for freeze and bit 0 for enable 2. A write to 05h takes effect immediately, whatever the freeze state.
- R7: Reserved bits read as 0 and ignore writes. The writable bits are 02h: 0x03, 03h: 0xB0, 04h: 0x4F and 05h: 0x09. A write to any other address changes nothing, and a read of such an address returns 0.
- R8: Bits [5:4] of active 03h select the auxiliary source. The mapping to `aux_sel` is: 00 gives 000 (idle), 01 gives 001 (input clock), 10 gives 010 (output clock) and 11 gives 100 (lock indicator). `lock_mode` is 1 only for code 11.
- R9: `lock_pol` is bit 0 of active 02h and `lock_od` is bit 1 of active 02h. Together they set the polarity and the driver type of the lock indicator.
- R10: `ctrl_port_en` is 1 only when all three enable bits are 1: active 03h bit 7, 05h bit 0 and active 04h bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| aux_sel | output | 3 | One-hot auxiliary source select: input clock, output clock, lock indicator |
| lock_mode | output | 1 | The auxiliary output carries the lock indicator |
| lock_pol | output | 1 | Lock indicator polarity |
| lock_od | output | 1 | Lock indicator driver type: 1 selects open drain |
| tune_field | output | 4 | Active tuning field from 04h |
| ctrl_port_en | output | 1 | Control-port mode enabled |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the staged window at 02h and the global register at 05h. With these values the full address space is reachable, so the bench writes and reads addresses below the window, above it and at 0xFF, and confirms that none of them alters state. A behavioural model tracks the staged copies, the active copies and the global register. It is compared on every clock through freeze/release sequences, repeated freeze writes without a release, a read and a write to the same register in one cycle, and each of the four routing codes.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int unsigned CB_DW     = 8;
  localparam int unsigned STAGE_CNT = 3;

  typedef logic [CB_DW-1:0] cb_byte_t;

  // writable bits per register
  localparam cb_byte_t MASK_LOCK  = 8'h03;
  localparam cb_byte_t MASK_ROUTE = 8'hB0;
  localparam cb_byte_t MASK_TUNE  = 8'h4F;
  localparam cb_byte_t MASK_GLB   = 8'h09;

  // field positions
  localparam int unsigned LOCK_POL_B = 0;
  localparam int unsigned LOCK_OD_B  = 1;
  localparam int unsigned EN1_B      = 7;
  localparam int unsigned SRC_LSB    = 4;
  localparam int unsigned EN3_B      = 6;
  localparam int unsigned FIELD_LSB  = 0;
  localparam int unsigned FIELD_W    = 4;
  localparam int unsigned FRZ_B      = 3;
  localparam int unsigned EN2_B      = 0;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'b00,
    SRC_REFIN  = 2'b01,
    SRC_PLLOUT = 2'b10,
    SRC_LOCK   = 2'b11
  } aux_src_e;

  function automatic cb_byte_t stage_mask(input int unsigned idx);
    case (idx)
      0:       return MASK_LOCK;
      1:       return MASK_ROUTE;
      default: return MASK_TUNE;
    endcase
  endfunction

endpackage

// File: rtl/cfgbank_stage.sv
module cfgbank_stage
  import cfgbank_pkg::*;
#(
  parameter cb_byte_t WMASK = 8'hFF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_hit,
  input  cb_byte_t wdata,
  input  logic     frz,
  input  logic     rel,
  output cb_byte_t stg_q,
  output cb_byte_t act_q
);

  cb_byte_t stg_d, act_d;
  logic     stg_en, act_en;

  always_comb begin
    stg_en = wr_hit;
    act_en = rel | (wr_hit & ~frz);
    stg_d  = wdata & WMASK;
    if (rel) act_d = stg_q;
    else     act_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      act_q <= '0;
    end else begin
      if (stg_en) stg_q <= stg_d;
      if (act_en) act_q <= act_d;
    end
  end

  p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !rel) |=> $stable(act_q));

  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> (act_q == $past(stg_q)));

  p_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !frz) |=> (act_q == ($past(wdata) & WMASK)));

  p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frz |-> (stg_q == act_q));

endmodule

// File: rtl/cfgbank_auxdec.sv
module cfgbank_auxdec
  import cfgbank_pkg::*;
(
  input  aux_src_e   src,
  output logic [2:0] aux_sel,
  output logic       lock_mode
);

  always_comb begin
    aux_sel   = 3'b000;
    lock_mode = 1'b0;
    case (src)
      SRC_REFIN:  aux_sel = 3'b001;
      SRC_PLLOUT: aux_sel = 3'b010;
      SRC_LOCK: begin
        aux_sel   = 3'b100;
        lock_mode = 1'b1;
      end
      default:    aux_sel = 3'b000;
    endcase
  end

endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STAGE_BASE = 2,
  parameter int unsigned GLB_ADDR   = 5
) (
  input  logic [ADDR_W-1:0]          addr,
  input  cb_byte_t [STAGE_CNT-1:0]   stg,
  input  cb_byte_t                   glb,
  output cb_byte_t                   data
);

  always_comb begin
    data = '0;
    for (int i = 0; i < STAGE_CNT; i++) begin
      if (addr == ADDR_W'(STAGE_BASE + i)) data = stg[i];
    end
    if (addr == ADDR_W'(GLB_ADDR)) data = glb;
  end

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STAGE_BASE = 2,
  parameter int unsigned GLB_ADDR   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CB_DW-1:0]    wdata,
  output logic [CB_DW-1:0]    rd_data,
  output logic [2:0]          aux_sel,
  output logic                lock_mode,
  output logic                lock_pol,
  output logic                lock_od,
  output logic [FIELD_W-1:0]  tune_field,
  output logic                ctrl_port_en
);

  localparam int unsigned IDX_LOCK  = 0;
  localparam int unsigned IDX_ROUTE = 1;
  localparam int unsigned IDX_TUNE  = 2;

  cb_byte_t [STAGE_CNT-1:0] stg, act;
  logic     [STAGE_CNT-1:0] stage_hit;
  cb_byte_t glb_q, glb_d, rd_d, rd_q;
  logic     glb_hit, glb_en, release_s, frz;

  // global register: never staged
  always_comb begin
    glb_hit   = wr_en && (addr == ADDR_W'(GLB_ADDR));
    glb_en    = glb_hit;
    glb_d     = wdata & MASK_GLB;
    frz       = glb_q[FRZ_B];
    release_s = glb_hit & frz & ~wdata[FRZ_B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_q <= '0;
    else if (glb_en) glb_q <= glb_d;
  end

  // staged configuration registers
  for (genvar g = 0; g < STAGE_CNT; g++) begin : g_stage
    assign stage_hit[g] = wr_en && (addr == ADDR_W'(STAGE_BASE + g));
    cfgbank_stage #(.WMASK(stage_mask(g))) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (stage_hit[g]),
      .wdata  (wdata),
      .frz    (frz),
      .rel    (release_s),
      .stg_q  (stg[g]),
      .act_q  (act[g])
    );
  end

  // read path
  cfgbank_rdmux #(
    .ADDR_W     (ADDR_W),
    .STAGE_BASE (STAGE_BASE),
    .GLB_ADDR   (GLB_ADDR)
  ) u_rdmux (
    .addr (addr),
    .stg  (stg),
    .glb  (glb_q),
    .data (rd_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // derived outputs from active copies
  cfgbank_auxdec u_auxdec (
    .src       (aux_src_e'(act[IDX_ROUTE][SRC_LSB +: 2])),
    .aux_sel   (aux_sel),
    .lock_mode (lock_mode)
  );

  assign lock_pol     = act[IDX_LOCK][LOCK_POL_B];
  assign lock_od      = act[IDX_LOCK][LOCK_OD_B];
  assign tune_field   = act[IDX_TUNE][FIELD_LSB +: FIELD_W];
  assign ctrl_port_en = act[IDX_ROUTE][EN1_B] & glb_q[EN2_B] & act[IDX_TUNE][EN3_B];

  // checks
  logic unmapped;
  always_comb begin
    unmapped = (addr != ADDR_W'(GLB_ADDR));
    for (int i = 0; i < STAGE_CNT; i++) begin
      if (addr == ADDR_W'(STAGE_BASE + i)) unmapped = 1'b0;
    end
  end

  p_enable_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_hit && !wdata[EN2_B]) |=> !ctrl_port_en);

  p_aux_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(aux_sel));

  p_lockmode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_mode |-> (aux_sel == 3'b100));

  p_unmapped_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rd_data == '0));

  p_freeze_imm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    glb_hit |=> (glb_q[FRZ_B] == $past(wdata[FRZ_B])));

  p_frozen_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !release_s) |=> ($stable(aux_sel) && $stable(tune_field) && $stable(lock_pol)));

endmodule

// File: tb/tb_cfgbank_top.sv
module tb_cfgbank_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [7:0] addr, wdata;
  logic [7:0] rd_data;
  logic [2:0] aux_sel;
  logic       lock_mode, lock_pol, lock_od, ctrl_port_en;
  logic [3:0] tune_field;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [7:0] m_stg [3];
  logic [7:0] m_act [3];
  logic [7:0] m_glb;
  logic [7:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgbank_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .aux_sel(aux_sel), .lock_mode(lock_mode),
    .lock_pol(lock_pol), .lock_od(lock_od), .tune_field(tune_field),
    .ctrl_port_en(ctrl_port_en)
  );

  function automatic logic [7:0] wmask(input int idx);
    if (idx == 0) return 8'h03;
    if (idx == 1) return 8'h4F & 8'hB0 | 8'hB0;
    return 8'h4F;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a >= 8'd2 && a <= 8'd4) return m_stg[a-2];
    if (a == 8'd5) return m_glb;
    return 8'h00;
  endfunction

  task automatic check(input string req, input string what, input int act_v, input int exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic compare_all();
    logic [2:0] e_sel;
    logic [1:0] src;
    src = m_act[1][5:4];
    case (src)
      2'b01:   e_sel = 3'b001;
      2'b10:   e_sel = 3'b010;
      2'b11:   e_sel = 3'b100;
      default: e_sel = 3'b000;
    endcase
    check({cur_req, "/R8"},  "aux_sel",      aux_sel,      e_sel);
    check({cur_req, "/R8"},  "lock_mode",    lock_mode,    src == 2'b11);
    check({cur_req, "/R9"},  "lock_pol",     lock_pol,     m_act[0][0]);
    check({cur_req, "/R9"},  "lock_od",      lock_od,      m_act[0][1]);
    check({cur_req, "/R2"},  "tune_field",   tune_field,   m_act[2][3:0]);
    check({cur_req, "/R10"}, "ctrl_port_en", ctrl_port_en,
          m_act[1][7] & m_glb[0] & m_act[2][6]);
    check({cur_req, "/R5"},  "rd_data",      rd_data,      m_rd);
  endtask

  task automatic step(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
    bit rel;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk);
    if (r) m_rd = model_read(a);
    rel = w && a == 8'd5 && m_glb[3] && !d[3];
    for (int i = 0; i < 3; i++) begin
      if (rel) m_act[i] = m_stg[i];
      if (w && a == 8'(i + 2)) begin
        m_stg[i] = d & wmask(i);
        if (!m_glb[3]) m_act[i] = d & wmask(i);
      end
    end
    if (w && a == 8'd5) m_glb = d & 8'h09;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    compare_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [7:0] a);
    step(1'b0, 1'b1, a, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < 3; i++) begin m_stg[i] = '0; m_act[i] = '0; end
    m_glb = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 2; a <= 5; a++) rd(8'(a));

    // R2 / R6 / R9 / R10: immediate writes with freeze clear
    cur_req = "R2";
    wr(8'h02, 8'hFF);
    wr(8'h03, 8'hFF);
    wr(8'h04, 8'hFF);
    cur_req = "R6";
    wr(8'h05, 8'hF7);
    cur_req = "R7";
    for (int a = 2; a <= 5; a++) rd(8'(a));

    // R8: each routing code
    cur_req = "R8";
    for (int s = 0; s < 4; s++) wr(8'h03, 8'h80 | 8'(s << 4));
    wr(8'h02, 8'h01);
    wr(8'h02, 8'h02);

    // R3: freeze and stage new values
    cur_req = "R6";
    wr(8'h05, 8'h09);
    cur_req = "R3";
    wr(8'h02, 8'h01);
    wr(8'h03, 8'h10);
    wr(8'h04, 8'h45);
    rd(8'h03);
    rd(8'h04);
    wr(8'h03, 8'h20);
    cur_req = "R6";
    wr(8'h05, 8'h09);
    cur_req = "R3";
    rd(8'h02);

    // R4: release commits everything at once
    cur_req = "R4";
    wr(8'h05, 8'h01);
    rd(8'h05);

    // R10: each enable dropped on its own
    cur_req = "R10";
    wr(8'h03, 8'hB0);
    wr(8'h04, 8'h40);
    wr(8'h05, 8'h00);
    wr(8'h05, 8'h01);
    wr(8'h04, 8'h0F);
    wr(8'h04, 8'h4F);
    wr(8'h03, 8'h30);
    wr(8'h03, 8'hB0);

    // R7: unmapped addresses
    cur_req = "R7";
    wr(8'h00, 8'hFF);
    wr(8'h01, 8'hFF);
    wr(8'h06, 8'h00);
    wr(8'hFF, 8'h00);
    rd(8'h00);
    rd(8'h06);
    rd(8'hFF);

    // R5: read and write to the same register in one cycle
    cur_req = "R5";
    step(1'b1, 1'b1, 8'h04, 8'h05);
    rd(8'h04);
    wr(8'h05, 8'h08);
    step(1'b1, 1'b1, 8'h02, 8'h03);
    rd(8'h02);
    cur_req = "R4";
    wr(8'h05, 8'h00);

    finish_run();
  end

endmodule